// File: doc/BRIEF.md
# Lockable Seconds Counter

The block keeps a 48-bit count of elapsed seconds for a chip's real-time clock. A slow tick strobe (nominally 32768 per second, given as a one-cycle enable in the system clock domain) feeds a prescaler. Each time the prescaler completes a second, the count advances by one. Software reaches the count through a 32-bit register port. The count is split into a low word holding bits 31:0 and a high word holding bits 47:32.

All configuration is write-protected. Software must first write two fixed key words, in order. Until it does, writes to the count, the trim value and the configuration register are dropped. A status bit in the configuration register shows when the block is unlocked. A freeze mode makes 48-bit reads coherent: reading the low word captures the high word, and the next high-word read returns that captured value.

A signed trim register corrects a slow or fast oscillator. The trim is counted in ticks per window, where a window is a fixed number of seconds (3600 by default). An accumulator spreads the lengthened or shortened seconds evenly across each window.

Top module: `rtc_secs_top`

## Requirements
- R1: After reset, the count is 0, the block is locked, the freeze mode is 0 and the trim is 0. Reading offsets 0x08, 0x0C, 0x10 and 0x50 returns 0.
- R2: Writing 0x83E70B13 to offset 0x70 and then 0x95A4F1E0 to offset 0x74 unlocks the block. Bit 23 of offset 0x50 then reads 1 and stays 1 until reset.
- R3: A second-key write whose value is wrong, or that does not directly follow a correct first-key write, restarts the key sequence. A later correct second-key write alone then does not unlock. A wrong value written to 0x70 also disarms the sequence.
- R4: While the block is locked, writes to 0x08, 0x0C, 0x10 and 0x50 have no effect.
- R5: With zero trim, the count rises by one on every TICKS_PER_SEC-th cycle in which tickEn is high. Cycles with tickEn low do not count.
- R6: Once unlocked, writing 0x08 loads count bits 31:0. Writing 0x0C loads count bits 47:32 from wrData bits 15:0 and ignores wrData bits 31:16, so they read back as 0. Either write restarts the prescaler, and a tick in the same cycle is dropped.
- R7: When bits 25:24 of 0x50 hold 2, a read of 0x08 captures the high word. The next read of 0x0C returns the captured value and releases the capture, so later reads of 0x0C return the live high word. With any other mode, 0x0C always reads the live high word.
- R8: The trim at 0x10 is a signed 32-bit value C, and its magnitude saturates at WINDOW_SECS. At every second end, the accumulator adds |C|. When the sum reaches WINDOW_SECS, the accumulator subtracts WINDOW_SECS and the next second lasts one tick longer (C > 0) or one tick shorter (C < 0).
- R9: From 2^48 − 1 the count wraps to 0 at the next second end.
- R10: A read returns its data on rdData, with rdValid high, in the cycle after rdEn. Key offsets and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per oscillator tick |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | High in the cycle after a read |

## Verification
A prescaler or accumulator holding a wrong value appears at the ports as a second that ends one tick early or late. The bench sees this on the next count read, because it reads exactly one tick before and at each expected second boundary. A stuck key state shows as bit 23 reading wrong on the read right after the second key write. A lost or stale capture shows as a high-word read that disagrees with the preceding low-word read across a carry into bit 32.

// File: rtl/rtc_secs_pkg.sv
package rtc_secs_pkg;
  localparam int REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_SEC_LO = 8'h08;
  localparam logic [REG_ADDR_W-1:0] ADDR_SEC_HI = 8'h0C;
  localparam logic [REG_ADDR_W-1:0] ADDR_TRIM   = 8'h10;
  localparam logic [REG_ADDR_W-1:0] ADDR_CFG    = 8'h50;
  localparam logic [REG_ADDR_W-1:0] ADDR_KEY_A  = 8'h70;
  localparam logic [REG_ADDR_W-1:0] ADDR_KEY_B  = 8'h74;

  localparam logic [31:0] KEY_A_VAL = 32'h83E70B13;
  localparam logic [31:0] KEY_B_VAL = 32'h95A4F1E0;

  localparam int CFG_OPEN_BIT = 23;
  localparam int CFG_MODE_LSB = 24;
  localparam logic [1:0] MODE_FREEZE = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic        loadLo;
    logic        loadHi;
    logic [31:0] data;
  } cntCmd_t;
endpackage

// File: rtl/rtc_secs_dp.sv
module rtc_secs_dp
  import rtc_secs_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WINDOW_SECS   = 3600,
  parameter int SEC_W         = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  cntCmd_t          cmd,
  input  logic [31:0]      trim,
  output logic [SEC_W-1:0] secs
);
  localparam int PRE_W = $clog2(TICKS_PER_SEC + 1);
  localparam int ACC_W = $clog2(WINDOW_SECS + 1);
  localparam int HI_W  = SEC_W - 32;

  logic [PRE_W-1:0] preCnt, preLimit;
  logic [ACC_W-1:0] acc, trimSat;
  logic [ACC_W:0]   accSum;
  logic [31:0]      trimAbs;
  logic             adjSlow, adjFast;
  logic             secEnd, secDone, loadAny, windowHit;
  logic             unusedBits;

  assign unusedBits = ^cmd.data[31:HI_W];

  // length of the current second, set by the previous second end
  always_comb begin
    if (adjSlow)      preLimit = PRE_W'(TICKS_PER_SEC);
    else if (adjFast) preLimit = PRE_W'(TICKS_PER_SEC - 2);
    else              preLimit = PRE_W'(TICKS_PER_SEC - 1);
  end

  assign loadAny = cmd.loadLo || cmd.loadHi;
  assign secEnd  = tickEn && (preCnt == preLimit);
  assign secDone = secEnd && !loadAny;

  // trim magnitude, saturated to one adjustment per second
  assign trimAbs   = trim[31] ? (~trim + 32'd1) : trim;
  assign trimSat   = (trimAbs >= 32'(WINDOW_SECS)) ? ACC_W'(WINDOW_SECS) : ACC_W'(trimAbs);
  assign accSum    = {1'b0, acc} + {1'b0, trimSat};
  assign windowHit = accSum >= (ACC_W+1)'(WINDOW_SECS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      acc     <= '0;
      adjSlow <= 1'b0;
      adjFast <= 1'b0;
      secs    <= '0;
    end else begin
      if (loadAny || secEnd) preCnt <= '0;
      else if (tickEn)       preCnt <= preCnt + PRE_W'(1);

      if (secDone) begin
        if (windowHit) acc <= ACC_W'(accSum - (ACC_W+1)'(WINDOW_SECS));
        else           acc <= ACC_W'(accSum);
        adjSlow <= windowHit && !trim[31];
        adjFast <= windowHit && trim[31];
      end

      if (cmd.loadLo)      secs[31:0]       <= cmd.data;
      else if (cmd.loadHi) secs[SEC_W-1:32] <= cmd.data[HI_W-1:0];
      else if (secDone)    secs             <= secs + SEC_W'(1);
    end
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    !loadAny |=> (secs == $past(secs) || secs == $past(secs) + SEC_W'(1)));

  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (secDone && secs == {SEC_W{1'b1}}) |=> secs == '0);

  assert_acc_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    acc < ACC_W'(WINDOW_SECS));

  assert_pre_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_W'(TICKS_PER_SEC));
endmodule

// File: rtl/rtc_secs_ctrl.sv
module rtc_secs_ctrl
  import rtc_secs_pkg::*;
#(
  parameter int SEC_W = 48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [31:0]           wrData,
  input  logic [SEC_W-1:0]      secs,
  output cntCmd_t               cmd,
  output logic [31:0]           trim,
  output logic [31:0]           rdData,
  output logic                  rdValid
);
  localparam int HI_W = SEC_W - 32;

  logic            unlocked, keyArmed, frozen;
  logic [1:0]      mode;
  logic [HI_W-1:0] frozenHi;

  always_comb begin
    cmd        = '0;
    cmd.data   = wrData;
    cmd.loadLo = wrEn && unlocked && (addr == ADDR_SEC_LO);
    cmd.loadHi = wrEn && unlocked && (addr == ADDR_SEC_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      keyArmed <= 1'b0;
      mode     <= '0;
      trim     <= '0;
      frozen   <= 1'b0;
      frozenHi <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (wrEn) begin
        case (addr)
          ADDR_KEY_A: keyArmed <= (wrData == KEY_A_VAL);
          ADDR_KEY_B: begin
            if (keyArmed && wrData == KEY_B_VAL) unlocked <= 1'b1;
            keyArmed <= 1'b0;
          end
          ADDR_CFG:  if (unlocked) mode <= wrData[CFG_MODE_LSB +: 2];
          ADDR_TRIM: if (unlocked) trim <= wrData;
          default: ;
        endcase
      end

      rdValid <= rdEn;
      if (rdEn) begin
        case (addr)
          ADDR_SEC_LO: begin
            rdData <= secs[31:0];
            if (mode == MODE_FREEZE) begin
              frozen   <= 1'b1;
              frozenHi <= secs[SEC_W-1:32];
            end
          end
          ADDR_SEC_HI: begin
            rdData <= 32'(frozen ? frozenHi : secs[SEC_W-1:32]);
            frozen <= 1'b0;
          end
          ADDR_TRIM: rdData <= trim;
          ADDR_CFG:  rdData <= (32'(mode) << CFG_MODE_LSB) | (32'(unlocked) << CFG_OPEN_BIT);
          default:   rdData <= '0;
        endcase
      end
    end
  end

  assert_open_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> ($stable(trim) && $stable(mode)));

  assert_freeze_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frozen) |-> $past(rdEn && addr == ADDR_SEC_LO && mode == MODE_FREEZE));
endmodule

// File: rtl/rtc_secs_top.sv
module rtc_secs_top
  import rtc_secs_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WINDOW_SECS   = 3600,
  parameter int SEC_W         = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid
);
  cntCmd_t          cmd;
  logic [31:0]      trim;
  logic [SEC_W-1:0] secs;

  rtc_secs_ctrl #(.SEC_W(SEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .secs(secs), .cmd(cmd), .trim(trim),
    .rdData(rdData), .rdValid(rdValid)
  );

  rtc_secs_dp #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .WINDOW_SECS(WINDOW_SECS), .SEC_W(SEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd), .trim(trim), .secs(secs)
  );
endmodule

// File: tb/rtc_secs_top_tb.sv
module rtc_secs_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  rtc_secs_top #(.TICKS_PER_SEC(8), .WINDOW_SECS(4), .SEC_W(48)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  // monitor: compare each read result against the scoreboard head
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected read data actual=%h expected=none", rdData);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'h08, 32'h0, "R1 low");
    rd(8'h0C, 32'h0, "R1 high");
    rd(8'h50, 32'h0, "R1 cfg");
    rd(8'h10, 32'h0, "R1 trim");
    // R4 locked writes dropped
    wr(8'h08, 32'd123); wr(8'h0C, 32'd7); wr(8'h10, 32'd5); wr(8'h50, 32'h0200_0000);
    rd(8'h08, 32'h0, "R4 low");
    rd(8'h0C, 32'h0, "R4 high");
    rd(8'h10, 32'h0, "R4 trim");
    rd(8'h50, 32'h0, "R4 cfg");
    // R3 key sequence restarts
    wr(8'h74, 32'h95A4F1E0);
    rd(8'h50, 32'h0, "R3 key B alone");
    wr(8'h70, 32'h83E70B13); wr(8'h74, 32'h12345678); wr(8'h74, 32'h95A4F1E0);
    rd(8'h50, 32'h0, "R3 wrong key B");
    wr(8'h70, 32'h83E70B13); wr(8'h70, 32'h0); wr(8'h74, 32'h95A4F1E0);
    rd(8'h50, 32'h0, "R3 wrong key A");
    // R2 unlock
    wr(8'h70, 32'h83E70B13); wr(8'h74, 32'h95A4F1E0);
    rd(8'h50, 32'h0080_0000, "R2 open bit");
    // R6 loads
    wr(8'h08, 32'h1000); wr(8'h0C, 32'hABCD_0005);
    rd(8'h0C, 32'h5, "R6 high reserved bits");
    rd(8'h08, 32'h1000, "R6 low");
    // R5 one second per 8 ticks
    ticks(7);
    rd(8'h08, 32'h1000, "R5 before boundary");
    ticks(1);
    rd(8'h08, 32'h1001, "R5 at boundary");
    // R6 load restarts prescaler
    ticks(5);
    wr(8'h08, 32'h2000);
    ticks(7);
    rd(8'h08, 32'h2000, "R6 restart before");
    ticks(1);
    rd(8'h08, 32'h2001, "R6 restart at");
    // R9 wrap
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'h0000_FFFF);
    ticks(8);
    rd(8'h08, 32'h0, "R9 low wrap");
    rd(8'h0C, 32'h0, "R9 high wrap");
    // R7 mode 0: high is live
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'h1);
    ticks(7);
    rd(8'h08, 32'hFFFF_FFFF, "R7 live low");
    ticks(1);
    rd(8'h0C, 32'h2, "R7 live high");
    // R7 freeze mode
    wr(8'h50, 32'h0200_0000);
    rd(8'h50, 32'h0280_0000, "R7 cfg mode");
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'h1);
    ticks(7);
    rd(8'h08, 32'hFFFF_FFFF, "R7 freeze low");
    ticks(1);
    rd(8'h0C, 32'h1, "R7 frozen high");
    rd(8'h0C, 32'h2, "R7 released high");
    wr(8'h50, 32'h0);
    // R8 positive trim: fifth second takes 9 ticks
    wr(8'h10, 32'd1); wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    ticks(32);
    rd(8'h08, 32'd4, "R8 four seconds");
    ticks(8);
    rd(8'h08, 32'd4, "R8 lengthened second");
    ticks(1);
    rd(8'h08, 32'd5, "R8 lengthened end");
    // R8 negative trim saturated: seconds of 7 ticks after the first
    wr(8'h10, 32'hFFFF_FFFC); wr(8'h08, 32'h0);
    ticks(8);
    rd(8'h08, 32'd1, "R8 first second");
    ticks(6);
    rd(8'h08, 32'd1, "R8 shortened before");
    ticks(1);
    rd(8'h08, 32'd2, "R8 shortened end");
    wr(8'h10, 32'hFFFF_FF9C);
    rd(8'h10, 32'hFFFF_FF9C, "R8 trim readback");
    ticks(7);
    rd(8'h08, 32'd3, "R8 saturated trim");
    // R10 key and unmapped reads
    rd(8'h70, 32'h0, "R10 key read");
    rd(8'h40, 32'h0, "R10 unmapped read");
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R10: pending reads actual=%0d expected=0", expQ.size());
    end
    summary();
  end
endmodule